// File: doc/BRIEF.md
# Boot-Time Register Loader

After reset, this block reads a small configuration image out of a byte-addressed memory and replays it as a sequence of internal register writes. A simple request/valid byte-read port asks for one byte at a time at increasing offsets. That port takes the place of a serial-memory reader. The image opens with an 8-byte header: a 16-bit big-endian record count followed by six filler bytes that must each be 0xFF. After the header come fixed 8-byte records. Each record holds a 32-bit register address and then 32-bit write data, both stored most significant byte first.

Each record is sent out on a register-write port with a valid/ready handshake. Once exactly the stated number of records has been written, the loader raises `done` and stays idle until the next reset. A header filler byte that is not 0xFF stops the load at once: no writes are issued, and `error` and `done` are both raised. This block does not cover the serial bus protocol or the register file that receives the writes.

Top module: `boot_cfg_loader`

## Requirements
- R1: The record count is taken from byte offsets 0 and 1, with offset 0 as its upper 8 bits. A count of 0x0100 therefore produces 256 writes.
- R2: Offsets 2 to 7 must each read 0xFF. On the first filler byte that does not, the loader issues no read beyond that byte and no write, and it raises `error` and `done`.
- R3: Record k occupies offsets 8+8k to 15+8k. Its first four bytes form `wr_addr` and its last four form `wr_data`, each with the lowest offset as bits 31:24.
- R4: Exactly count writes are issued, in memory order. The bytes read are offsets 0 to 7+8*count, and nothing at a higher offset is requested.
- R5: A count of zero ends the load after exactly the 8 header bytes are read, with `done` high, `error` low and no write.
- R6: At most one read is outstanding at a time. Once `rd_req` is raised it stays high with `rd_addr` stable until `rd_valid` is sampled, and successive requests use consecutive offsets starting at 0.
- R7: `wr_valid` holds `wr_addr` and `wr_data` stable until `wr_ready` is sampled high. `rd_req` and `wr_valid` are never high together, so the next fetch starts only after the write is accepted.
- R8: While reset is held, `rd_req`, `wr_valid`, `done` and `error` are low. Once `done` rises it stays high until reset, with `rd_req` and `wr_valid` low.
- R9: `wr_valid` rises in the cycle after the edge that samples a record's last byte. `done` rises in the cycle after the edge that accepts the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | output | 1 | Byte read request, held until rd_valid |
| rd_addr | output | 16 | Byte offset being requested |
| rd_valid | input | 1 | Returned byte is valid this cycle |
| rd_byte | input | 8 | Returned byte |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Register write accepted when high with wr_valid |
| wr_addr | output | 32 | Register address of the pending write |
| wr_data | output | 32 | Data of the pending write |
| done | output | 1 | Load finished (sticky until reset) |
| error | output | 1 | Header filler byte was not 0xFF |

## Verification
Every output is decoded from registered state, so each result shows up one cycle after the edge that causes it. `rd_req` rises one cycle after reset is released. The next offset is requested in the cycle after a byte is sampled. `wr_valid` rises one cycle after a record's eighth byte, and `done` rises one cycle after the final write is accepted, the zero-count header ends, or a bad filler byte is sampled. The bench changes its inputs on rising edges and samples the outputs on falling edges, so each check lands in the cycle that follows the edge it depends on. Counters in the memory model record how many bytes were read, the highest offset read, and any break in offset order or in request stability.

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader #(
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req,
  output logic [OFS_W-1:0]  rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_byte,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic              error
);
  localparam int HDR_BYTES = 8;
  localparam int REC_BYTES = (ADDR_W + DATA_W) / 8;
  localparam int BI_W      = $clog2(REC_BYTES);
  localparam int REC_W     = ADDR_W + DATA_W;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WRITE, S_FIN} st_t;

  st_t              st;
  logic [OFS_W-1:0] ofs;
  logic [15:0]      left;
  logic [BI_W-1:0]  bidx;
  logic [REC_W-1:0] rec;
  logic             err_q;

  wire in_hdr   = ofs < OFS_W'(HDR_BYTES);
  wire hdr_last = ofs == OFS_W'(HDR_BYTES - 1);
  wire rec_last = bidx == BI_W'(REC_BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ofs   <= '0;
      left  <= '0;
      bidx  <= '0;
      rec   <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: st <= S_FETCH;
        S_FETCH: if (rd_valid) begin
          ofs <= ofs + 1'b1;
          if (in_hdr) begin
            if (ofs == '0)                  left[15:8] <= rd_byte;
            else if (ofs == OFS_W'(1))      left[7:0]  <= rd_byte;
            else if (rd_byte != 8'hFF) begin
              err_q <= 1'b1;
              st    <= S_FIN;
            end else if (hdr_last && left == 16'd0) begin
              st <= S_FIN;
            end
          end else begin
            rec <= {rec[REC_W-9:0], rd_byte};
            if (rec_last) begin
              bidx <= '0;
              st   <= S_WRITE;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        S_WRITE: if (wr_ready) begin
          left <= left - 16'd1;
          st   <= (left == 16'd1) ? S_FIN : S_FETCH;
        end
        default: st <= S_FIN;
      endcase
    end
  end

  assign rd_req   = st == S_FETCH;
  assign rd_addr  = ofs;
  assign wr_valid = st == S_WRITE;
  assign wr_addr  = rec[REC_W-1:DATA_W];
  assign wr_data  = rec[DATA_W-1:0];
  assign done     = st == S_FIN;
  assign error    = err_q;

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_valid));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !rd_req && !wr_valid);

  // R2
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R9
  last_wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && left == 16'd1 |=> done);
endmodule

// File: tb/boot_cfg_loader_tb.sv
module boot_cfg_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req, rd_valid = 1'b0;
  logic [15:0] rd_addr;
  logic [7:0]  rd_byte = 8'h00;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic        done, error;

  always #2 clk = ~clk;

  boot_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .error(error));

  localparam logic [63:0] RECS [4] = '{
    64'h0001_D108_0102_0304, 64'h8000_0000_FFFF_FFFF,
    64'h0000_0004_0000_0000, 64'h1234_5678_9ABC_DEF0};
  // {count, read latency, write latency}
  localparam int SCN [4][3] = '{'{1,0,0}, '{3,2,1}, '{4,0,3}, '{2,5,0}};

  logic [7:0]  mem [0:4095];
  logic [31:0] exp_a [0:299], exp_d [0:299], act_a [0:299], act_d [0:299];
  int rd_lat = 0, wr_lat = 0;
  int nchk = 0, nerr = 0, cyc = 0;
  int nrd, max_ofs, seq_bad, overlap_bad, nwr, lat_cnt, wcnt, next_exp;
  logic busy;
  logic [15:0] addr_l;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; busy <= 1'b0; nrd <= 0; max_ofs <= -1;
      seq_bad <= 0; next_exp <= 0; lat_cnt <= 0; addr_l <= '0;
    end else if (rd_valid) begin
      rd_valid <= 1'b0;
    end else if (busy) begin
      if (!rd_req || rd_addr != addr_l) seq_bad <= seq_bad + 1;
      if (lat_cnt == 0) begin
        rd_valid <= 1'b1; rd_byte <= mem[addr_l[11:0]]; busy <= 1'b0;
        nrd <= nrd + 1;
        if (int'(addr_l) > max_ofs) max_ofs <= int'(addr_l);
      end else lat_cnt <= lat_cnt - 1;
    end else if (rd_req) begin
      if (int'(rd_addr) != next_exp) seq_bad <= seq_bad + 1;
      next_exp <= next_exp + 1;
      busy <= 1'b1; addr_l <= rd_addr; lat_cnt <= rd_lat;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      wr_ready <= 1'b0; wcnt <= 0; nwr <= 0; overlap_bad <= 0;
    end else begin
      if (rd_req && wr_valid) overlap_bad <= overlap_bad + 1;
      if (wr_ready) begin
        wr_ready <= 1'b0;
        if (wr_valid) begin
          if (nwr < 300) begin act_a[nwr] <= wr_addr; act_d[nwr] <= wr_data; end
          nwr <= nwr + 1;
        end
      end else if (wr_valid) begin
        if (wcnt == wr_lat) begin wr_ready <= 1'b1; wcnt <= 0; end
        else wcnt <= wcnt + 1;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h5A;
  endtask

  task automatic put_hdr(input int cnt, input int bad);
    mem[0] = cnt[15:8]; mem[1] = cnt[7:0];
    for (int i = 2; i < 8; i++) mem[i] = (i == bad) ? 8'hFE : 8'hFF;
  endtask

  task automatic put_rec(input int k, input logic [63:0] r);
    for (int b = 0; b < 8; b++) mem[8 + 8*k + b] = r[63 - 8*b -: 8];
    exp_a[k] = r[63:32]; exp_d[k] = r[31:0];
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
  endtask

  task automatic check_writes(input string req, input int cnt);
    chk(nwr == cnt, req, "write count", nwr, cnt);
    for (int k = 0; k < cnt && k < nwr; k++) begin
      chk(act_a[k] == exp_a[k], "R3", $sformatf("addr of write %0d", k), act_a[k], exp_a[k]);
      chk(act_d[k] == exp_d[k], "R3", $sformatf("data of write %0d", k), act_d[k], exp_d[k]);
    end
  endtask

  initial begin
    // R8: reset state
    repeat (2) @(negedge clk);
    chk(!rd_req && !wr_valid && !done && !error, "R8", "outputs in reset",
        {rd_req, wr_valid, done, error}, 0);

    // table-driven loads
    for (int s = 0; s < 4; s++) begin
      int cnt;
      cnt = SCN[s][0]; rd_lat = SCN[s][1]; wr_lat = SCN[s][2];
      clear_mem(); put_hdr(cnt, -1);
      for (int k = 0; k < cnt; k++) put_rec(k, RECS[(k + s) % 4]);
      do_reset(); wait_done();
      chk(done && !error, "R2", "done without error", {done, error}, 2'b10);
      check_writes("R4", cnt);
      chk(nrd == 8 + 8*cnt, "R4", "bytes read", nrd, 8 + 8*cnt);
      chk(seq_bad == 0, "R6", "read order/stability faults", seq_bad, 0);
      chk(overlap_bad == 0, "R7", "read during write", overlap_bad, 0);
    end

    // R4: worked example, nothing at or above 0x18 read
    rd_lat = 1; wr_lat = 1;
    clear_mem(); put_hdr(2, -1);
    put_rec(0, 64'h0001_D108_0102_0304); put_rec(1, 64'h0001_D114_0506_0708);
    do_reset(); wait_done();
    check_writes("R4", 2);
    chk(max_ofs == 23, "R4", "highest offset read", max_ofs, 23);

    // R5: zero count
    clear_mem(); put_hdr(0, -1);
    do_reset(); wait_done();
    chk(done && !error && nwr == 0, "R5", "zero count end state",
        {done, error, 8'(nwr)}, 10'h200);
    chk(nrd == 8, "R5", "bytes read", nrd, 8);

    // R2: bad filler at offsets 3 and 6
    for (int b = 3; b < 8; b += 3) begin
      clear_mem(); put_hdr(2, b); put_rec(0, RECS[0]); put_rec(1, RECS[1]);
      do_reset(); wait_done();
      chk(done && error, "R2", "error and done", {done, error}, 2'b11);
      chk(nwr == 0, "R2", "writes after bad header", nwr, 0);
      chk(nrd == b + 1, "R2", "bytes read before stop", nrd, b + 1);
    end

    // R1: count 0x0100 with MSB at offset 0
    rd_lat = 0; wr_lat = 0;
    clear_mem(); put_hdr(256, -1);
    for (int k = 0; k < 256; k++)
      put_rec(k, {32'h0002_0000 + 32'(k*4), 32'(k) * 32'h0101_0101 ^ 32'hC3C3_0000});
    do_reset(); wait_done();
    chk(nwr == 256, "R1", "writes for count 0x0100", nwr, 256);
    chk(act_a[255] == exp_a[255] && act_d[255] == exp_d[255], "R1", "last write data",
        act_d[255], exp_d[255]);

    // R8: done sticky, idle
    begin
      int n0;
      n0 = nrd;
      repeat (20) @(negedge clk);
      chk(done && !rd_req && !wr_valid && nrd == n0, "R8", "idle after done",
          {done, rd_req, wr_valid}, 3'b100);
    end

    // R9 / R7: output timing with a slow write acceptor
    rd_lat = 0; wr_lat = 2;
    clear_mem(); put_hdr(1, -1); put_rec(0, RECS[3]);
    do_reset();
    for (int i = 0; i < 500 && !(rd_valid && rd_addr == 16'd15); i++) @(negedge clk);
    chk(!wr_valid, "R9", "wr_valid before last byte sampled", wr_valid, 0);
    @(negedge clk);
    chk(wr_valid && wr_addr == exp_a[0], "R9", "write one cycle after last byte",
        wr_addr, exp_a[0]);
    for (int i = 0; i < 50 && !(wr_valid && wr_ready); i++) begin
      chk(!rd_req && wr_data == exp_d[0], "R7", "held write while waiting", wr_data, exp_d[0]);
      @(negedge clk);
    end
    chk(!done, "R9", "done before acceptance", done, 0);
    @(negedge clk);
    chk(done && !error, "R9", "done one cycle after final accept", done, 1);

    summary();
    $finish;
  end
endmodule